// File: doc/BRIEF.md
# Local-Remote Tick Difference Counter

This block tracks how far one remote node's tick stream has moved relative to the local node's tick stream. A clock generator instantiates one copy per remote node. Each copy holds two pipes of outstanding ticks, one fed by the local tick pulse and one fed by the remote tick pulse. A tick that has shown up on both sides is cancelled out of both pipes together, so that only the ticks that make up the difference stay stored.

Cancellation follows a strict order. Tick 0 sits in both pipes from reset. The oldest stored tick pair is removed only once the next tick is present on both sides, and at most one pair is removed per clock. A removal counter records how many pairs have gone. From the pipe occupancies the block derives two status flags for the tick generator. The first says the remote node is ahead of the local clock. The second says the remote node lags the local clock by no more than the pipelining window `WIN_X`.

A tick that arrives at a full pipe, with no removal in the same cycle, is dropped and raises a sticky error.

Top module: `tick_diff_counter`

## Requirements
- R1: After reset each pipe holds exactly one tick (tick 0), `rem_ahead` is 0, `rem_in_window` is 1 and `pipe_overflow` is 0.
- R2: A 1 on `loc_tick` or `rem_tick` at a rising edge adds one tick to that side's pipe. The flags reflect the new occupancy right after that edge.
- R3: When both tick inputs are 1 at the same edge, both ticks are accepted before removal is evaluated for that edge.
- R4: A pair is removed from both pipes at an edge only if each pipe, counting that edge's arrivals, holds at least two ticks. At most one pair is removed per edge, and each removal advances the removal counter by exactly one.
- R5: `rem_ahead` is 1 exactly when the local pipe holds one tick and the remote pipe holds two or more.
- R6: `rem_in_window` is 1 exactly when the local occupancy does not exceed the remote occupancy plus `WIN_X` (default 4).
- R7: A tick that arrives at a pipe already holding `DEPTH` ticks (default 8), at an edge with no removal, is dropped and sets `pipe_overflow`. The flag stays 1 until reset. Occupancy always stays between 1 and `DEPTH`.
- R8: Let R and L be the counts of accepted remote and local ticks. Whenever no removal is pending, `rem_ahead` equals R-L > 0 and `rem_in_window` equals L-R <= `WIN_X`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_tick | input | 1 | One-cycle pulse per tick issued by the local node |
| rem_tick | input | 1 | One-cycle pulse per tick received from the remote node |
| rem_ahead | output | 1 | Remote node is ahead of the local clock |
| rem_in_window | output | 1 | Remote node lags by at most WIN_X ticks |
| pipe_overflow | output | 1 | Sticky: a tick was dropped at a full pipe |

## Verification
The bench targets ticks that arrive together. A design that evaluated removal before accepting them would leave a pair uncancelled and report the remote as ahead or behind by one. It walks the local side exactly `WIN_X` and then `WIN_X`+1 ticks ahead. An off-by-one in the window comparison shows up there as an early or late drop of `rem_in_window`. It fills a pipe past `DEPTH`, which catches overflow that is never flagged, a flag that clears, or occupancy that wraps. Long random interleavings compare both flags with the signed difference of the accepted tick counts, so lost or duplicated removals show up as flag mismatches.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  // Remote is ahead: local pipe down to its single tick, remote holds more.
  function automatic logic ahead_of(input int unsigned lo, input int unsigned ro);
    return (lo == 1) && (ro >= 2);
  endfunction

  // Remote lags by no more than x ticks.
  function automatic logic within_win(input int unsigned lo, input int unsigned ro,
                                      input int unsigned x);
    return lo <= ro + x;
  endfunction

  // A pair can be cancelled once both sides, arrivals included, hold two ticks.
  function automatic logic pair_ready(input int unsigned lo, input int unsigned ro,
                                      input int unsigned lt, input int unsigned rt);
    return (lo + lt >= 2) && (ro + rt >= 2);
  endfunction

endpackage

// File: rtl/tdc_pipe.sv
module tdc_pipe #(
  parameter int DEPTH = 8,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             pop,
  output logic [OCC_W-1:0] occ,
  output logic             ovf_evt
);

  logic full;
  logic accept;

  assign full    = (occ == OCC_W'(DEPTH));
  assign accept  = tick && (!full || pop);
  assign ovf_evt = tick && full && !pop;

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= OCC_W'(1);
    else        occ <= occ + OCC_W'(accept) - OCC_W'(pop);
  end

  AST_OCC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (occ >= OCC_W'(1)) && (occ <= OCC_W'(DEPTH))); // R7

  AST_POP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (32'(occ) + 32'(tick) >= 2)); // R4

endmodule

// File: rtl/tdc_status.sv
module tdc_status #(
  parameter int WIN_X = 4,
  parameter int OCC_W = 4
) (
  input  logic [OCC_W-1:0] lo_occ,
  input  logic [OCC_W-1:0] ro_occ,
  output logic             ahead,
  output logic             in_win
);
  import tdc_pkg::*;

  always_comb begin
    ahead  = ahead_of(32'(lo_occ), 32'(ro_occ));
    in_win = within_win(32'(lo_occ), 32'(ro_occ), WIN_X);
  end

endmodule

// File: rtl/tick_diff_counter.sv
module tick_diff_counter #(
  parameter int WIN_X = 4,
  parameter int DEPTH = WIN_X + 4,
  parameter int RMC_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loc_tick,
  input  logic rem_tick,
  output logic rem_ahead,
  output logic rem_in_window,
  output logic pipe_overflow
);
  import tdc_pkg::*;

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] lo_occ, ro_occ;
  logic             lo_ovf, ro_ovf;
  logic             pop_pair;
  logic [RMC_W-1:0] rm_cnt;

  assign pop_pair = pair_ready(32'(lo_occ), 32'(ro_occ), 32'(loc_tick), 32'(rem_tick));

  tdc_pipe #(.DEPTH(DEPTH)) u_loc_pipe (
    .clk(clk), .rst_n(rst_n), .tick(loc_tick), .pop(pop_pair),
    .occ(lo_occ), .ovf_evt(lo_ovf)
  );

  tdc_pipe #(.DEPTH(DEPTH)) u_rem_pipe (
    .clk(clk), .rst_n(rst_n), .tick(rem_tick), .pop(pop_pair),
    .occ(ro_occ), .ovf_evt(ro_ovf)
  );

  tdc_status #(.WIN_X(WIN_X), .OCC_W(OCC_W)) u_status (
    .lo_occ(lo_occ), .ro_occ(ro_occ),
    .ahead(rem_ahead), .in_win(rem_in_window)
  );

  // Removal order: the pair removed next is always tick number rm_cnt.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rm_cnt        <= '0;
      pipe_overflow <= 1'b0;
    end else begin
      if (pop_pair) rm_cnt <= rm_cnt + RMC_W'(1);
      if (lo_ovf || ro_ovf) pipe_overflow <= 1'b1;
    end
  end

  AST_RM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pop_pair |=> (rm_cnt == $past(rm_cnt) + RMC_W'(1))); // R4

  AST_RM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_pair |=> $stable(rm_cnt)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_overflow |=> pipe_overflow); // R7

  AST_AHEAD_ONE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    rem_ahead |-> (lo_occ == OCC_W'(1))); // R5

  AST_EQUAL_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_occ == ro_occ) |-> (rem_in_window && !rem_ahead)); // R6

  AST_BOTH_TICKS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_tick && rem_tick && !pipe_overflow && (lo_occ < OCC_W'(DEPTH))
     && (ro_occ < OCC_W'(DEPTH))) |-> pop_pair); // R3

endmodule

// File: tb/tick_diff_counter_bench.sv
`timescale 1ns/1ps
module tick_diff_counter_bench;
  localparam int X = 4;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_tick = 1'b0;
  logic rem_tick = 1'b0;
  logic rem_ahead, rem_in_window, pipe_overflow;

  always #4 clk = ~clk;

  tick_diff_counter #(.WIN_X(X), .DEPTH(D)) u_tick_diff_counter (
    .clk(clk), .rst_n(rst_n), .loc_tick(loc_tick), .rem_tick(rem_tick),
    .rem_ahead(rem_ahead), .rem_in_window(rem_in_window), .pipe_overflow(pipe_overflow)
  );

  typedef struct {
    logic  ah;
    logic  wn;
    logic  er;
    bit    settled;
    int    diff;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int m_lo = 1, m_ro = 1;
  bit m_err = 0;
  int acc_l = 0, acc_r = 0;
  bit done = 0;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of ticks, advances the model, pushes the expectation.
  task automatic step(input bit l, input bit r, input string tag);
    int  nl, nr;
    bit  pr;
    exp_t e;
    loc_tick = l;
    rem_tick = r;
    @(posedge clk);
    nl = m_lo + int'(l);
    nr = m_ro + int'(r);
    pr = (nl > 1) && (nr > 1);
    if (l) begin
      if (m_lo == D && !pr) begin m_err = 1; nl = m_lo; end
      else acc_l++;
    end
    if (r) begin
      if (m_ro == D && !pr) begin m_err = 1; nr = m_ro; end
      else acc_r++;
    end
    if (pr) begin nl--; nr--; end
    m_lo = nl;
    m_ro = nr;
    e.ah = (m_lo == 1) && (m_ro > 1);
    e.wn = (m_lo - m_ro) <= X;
    e.er = m_err;
    e.settled = !((m_lo > 1) && (m_ro > 1));
    e.diff = acc_r - acc_l;
    e.tag = tag;
    q.push_back(e);
    #1;
    loc_tick = 1'b0;
    rem_tick = 1'b0;
  endtask

  // Monitor: compares the design after each edge, away from the edge.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && q.size() > 0) begin
      e = q.pop_front();
      check(e.tag, rem_ahead, e.ah, "rem_ahead");
      check(e.tag, rem_in_window, e.wn, "rem_in_window");
      check(e.tag, pipe_overflow, e.er, "pipe_overflow");
      if (e.settled && !e.er) begin
        check("R8", rem_ahead, logic'(e.diff > 0), "ahead_vs_diff");
        check("R8", rem_in_window, logic'(-e.diff <= X), "window_vs_diff");
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rem_ahead, 1'b0, "rem_ahead");
    check("R1", rem_in_window, 1'b1, "rem_in_window");
    check("R1", pipe_overflow, 1'b0, "pipe_overflow");

    // R2: single arrivals on each side
    step(1, 0, "R2");
    step(0, 1, "R4");
    // R5: remote pulls ahead, then local catches up with removals
    step(0, 1, "R5");
    step(0, 1, "R5");
    step(1, 0, "R4");
    step(1, 0, "R4");
    // R6: local runs ahead to the window edge and one past it
    for (int i = 0; i < X; i++) step(1, 0, "R6");
    step(1, 0, "R6");
    for (int i = 0; i < X + 1; i++) step(0, 1, "R4");
    // R3: simultaneous ticks
    step(1, 1, "R3");
    step(0, 1, "R5");
    step(1, 1, "R3");
    step(1, 0, "R3");
    // R8: random interleavings kept clear of the pipe limit
    for (int i = 0; i < 3000; i++) begin
      bit l, r;
      l = ($urandom % 2 == 1) && (m_lo < D - 1);
      r = ($urandom % 2 == 1) && (m_ro < D - 1);
      step(l, r, "R8");
    end
    // R7: overflow the local pipe, then confirm the error stays
    for (int i = 0; i < 2 * D + 4; i++) step(1, 0, "R7");
    for (int i = 0; i < 4; i++) step(0, 0, "R7");
    for (int i = 0; i < 3; i++) step(0, 1, "R7");
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule